// File: doc/BRIEF.md
# Shared Word and Byte Memory

This block is one byte-organized storage array that a small processor sees through two windows at once. The data window moves 32-bit words. It is addressed in word units and has separate read and write strobes. The instruction window returns single bytes. It is addressed directly by the program counter, with no scaling. A third, write-only byte port lets the environment place a program image into the array before or while the core runs.

Both windows see the same bytes. A word written through the data window can be fetched back one byte at a time, lowest byte first. Bytes that have not been written since reset read as zero. Any access that falls outside the array raises an error flag one cycle after the request and returns zero data.

Top module: `wb_shared_mem`

## Requirements
- R1: A word access at word address A uses byte addresses 4A to 4A+3. Writing word address A and then fetching program-counter value 4A returns the least significant byte of the written word.
- R2: Words are little-endian. Byte 4A+k holds bits [8k+7:8k] of the word, for k = 0 to 3. A word read assembles the four bytes in that same order.
- R3: A fetch with `if_req` high returns the single byte at byte address `if_pc` on `if_byte` in the next cycle, with `if_valid` high for exactly that cycle.
- R4: A word read with `wd_rd` high returns the word on `wd_rdata` in the next cycle, with `wd_valid` high for exactly that cycle. `wd_valid` is low in every cycle that does not follow a read strobe.
- R5: A byte that has not been written since reset reads as zero through either window. This also holds for the unwritten bytes of a word whose other bytes were written.
- R6: A word access is out of range when 4A+3 exceeds MEM_BYTES-1. One cycle after such a read or write, `wd_err` is high. Read data is zero, and the write does not change any stored byte. An in-range access, or a cycle with no strobe, gives `wd_err` low.
- R7: A fetch with `if_pc` greater than MEM_BYTES-1 raises `if_err` in the response cycle with `if_byte` zero.
- R8: With `pl_en` high, the 8-bit `pl_data` is stored at byte address `pl_addr`. A preload outside the array is ignored. If a word write and a preload target the same byte in the same cycle, the word write wins.
- R9: A fetch or word read in the same cycle as a word write to the same bytes returns the contents from before the write.
- R10: While `rst_n` is low, all valid and error outputs are low and both data outputs are zero. After reset, every byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_addr | input | WA_W | Word address of the data window |
| wd_rd | input | 1 | Word read strobe |
| wd_wr | input | 1 | Word write strobe |
| wd_wdata | input | 32 | Word to write |
| wd_rdata | output | 32 | Word read result |
| wd_valid | output | 1 | Pulses with a word read result |
| wd_err | output | 1 | Word access was out of range |
| if_pc | input | PC_W | Byte address of the fetch |
| if_req | input | 1 | Fetch request |
| if_byte | output | 8 | Fetched byte |
| if_valid | output | 1 | Pulses with a fetch result |
| if_err | output | 1 | Fetch was out of range |
| pl_en | input | 1 | Preload strobe |
| pl_addr | input | PC_W | Preload byte address |
| pl_data | input | 8 | Preload byte |

## Verification
A corrupted fill mark or a misrouted byte lane appears on the first read of the affected bytes. A corrupted fill mark shows as a nonzero byte where zero is expected, or as zero where data should be. A misrouted lane shows as swapped bytes, either in the next word read or in a fetch at 4A+k. A wrong range decision shows one cycle later as a missing or spurious `wd_err` or `if_err`. A write that should have been suppressed leaves a visible trace only when an aliased in-range word is read back, so the test reads word 0 after an out-of-range write.

// File: rtl/membank_pkg.sv
package membank_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  // Byte lane k of a little-endian word.
  function automatic byte_t lane_of(input word_t w, input int k);
    return w[k*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/wb_addr_map.sv
module wb_addr_map
  import membank_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int WA_W      = 10,
  parameter int PC_W      = 11,
  parameter int IDX_W     = 10
) (
  input  logic [WA_W-1:0]  word_addr,
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  pl_addr,
  output logic [IDX_W-1:0] word_base,
  output logic             word_ok,
  output logic [IDX_W-1:0] pc_idx,
  output logic             pc_ok,
  output logic [IDX_W-1:0] pl_idx,
  output logic             pl_ok
);
  localparam int WB_W = WA_W + 3;
  localparam int PB_W = PC_W + 1;
  localparam logic [WB_W-1:0] LAST_W = WB_W'(MEM_BYTES - 1);
  localparam logic [PB_W-1:0] LAST_P = PB_W'(MEM_BYTES - 1);

  logic [WB_W-1:0] byte_lo;
  logic [WB_W-1:0] byte_hi;

  // Word address scaled by four; the top byte of the word decides the range.
  always_comb begin
    byte_lo   = {1'b0, word_addr, 2'b00};
    byte_hi   = byte_lo + WB_W'(LANES - 1);
    word_ok   = (byte_hi <= LAST_W);
    word_base = IDX_W'(byte_lo);
  end

  // Fetch and preload use byte addresses as given.
  always_comb begin
    pc_ok  = ({1'b0, pc} <= LAST_P);
    pc_idx = IDX_W'(pc);
    pl_ok  = ({1'b0, pl_addr} <= LAST_P);
    pl_idx = IDX_W'(pl_addr);
  end
endmodule

// File: rtl/wb_byte_array.sv
module wb_byte_array
  import membank_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int IDX_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] word_base,
  input  logic             wr_en,
  input  word_t            wr_data,
  input  logic             pl_en,
  input  logic [IDX_W-1:0] pl_idx,
  input  byte_t            pl_data,
  input  logic [IDX_W-1:0] fe_idx,
  output word_t            rd_word,
  output byte_t            fe_byte
);
  byte_t                cells [MEM_BYTES];
  logic [MEM_BYTES-1:0] filled;
  logic [MEM_BYTES-1:0] filled_d;
  logic                 filled_en;
  logic [IDX_W-1:0]     lane_idx [LANES];

  // One index per byte lane of the word window.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_idx[k] = word_base + IDX_W'(k);
    assign rd_word[k*BYTE_W +: BYTE_W] =
      filled[lane_idx[k]] ? cells[lane_idx[k]] : '0;
  end

  assign fe_byte = filled[fe_idx] ? cells[fe_idx] : '0;

  // Storage cells carry no reset; the fill map masks stale contents.
  // The word write comes last so it wins over a preload of the same byte.
  always_ff @(posedge clk) begin
    if (pl_en) cells[pl_idx] <= pl_data;
    if (wr_en) begin
      for (int k = 0; k < LANES; k++) cells[lane_idx[k]] <= lane_of(wr_data, k);
    end
  end

  // Fill map next state.
  always_comb begin
    filled_en = pl_en | wr_en;
    filled_d  = filled;
    if (pl_en) filled_d[pl_idx] = 1'b1;
    if (wr_en) begin
      for (int k = 0; k < LANES; k++) filled_d[lane_idx[k]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         filled <= '0;
    else if (filled_en) filled <= filled_d;
  end
endmodule

// File: rtl/wb_resp_stage.sv
module wb_resp_stage
  import membank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wd_rd,
  input  logic  wd_wr,
  input  logic  word_ok,
  input  word_t rd_word,
  input  logic  if_req,
  input  logic  pc_ok,
  input  byte_t fe_byte,
  output word_t wd_rdata,
  output logic  wd_valid,
  output logic  wd_err,
  output byte_t if_byte,
  output logic  if_valid,
  output logic  if_err
);
  word_t rdata_d;
  logic  rdata_en;
  logic  wvalid_d;
  logic  werr_d;
  byte_t fbyte_d;
  logic  fbyte_en;
  logic  fvalid_d;
  logic  ferr_d;

  // Next-state logic.
  always_comb begin
    rdata_en = wd_rd;
    rdata_d  = word_ok ? rd_word : '0;
    wvalid_d = wd_rd;
    werr_d   = (wd_rd | wd_wr) & ~word_ok;
    fbyte_en = if_req;
    fbyte_d  = pc_ok ? fe_byte : '0;
    fvalid_d = if_req;
    ferr_d   = if_req & ~pc_ok;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_rdata <= '0;
      wd_valid <= 1'b0;
      wd_err   <= 1'b0;
      if_byte  <= '0;
      if_valid <= 1'b0;
      if_err   <= 1'b0;
    end else begin
      if (rdata_en) wd_rdata <= rdata_d;
      if (fbyte_en) if_byte  <= fbyte_d;
      wd_valid <= wvalid_d;
      wd_err   <= werr_d;
      if_valid <= fvalid_d;
      if_err   <= ferr_d;
    end
  end
endmodule

// File: rtl/wb_shared_mem.sv
module wb_shared_mem
  import membank_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int WA_W      = 10,
  parameter int PC_W      = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WA_W-1:0]     wd_addr,
  input  logic                wd_rd,
  input  logic                wd_wr,
  input  logic [WORD_W-1:0]   wd_wdata,
  output logic [WORD_W-1:0]   wd_rdata,
  output logic                wd_valid,
  output logic                wd_err,
  input  logic [PC_W-1:0]     if_pc,
  input  logic                if_req,
  output logic [BYTE_W-1:0]   if_byte,
  output logic                if_valid,
  output logic                if_err,
  input  logic                pl_en,
  input  logic [PC_W-1:0]     pl_addr,
  input  logic [BYTE_W-1:0]   pl_data
);
  localparam int IDX_W = $clog2(MEM_BYTES);

  logic [IDX_W-1:0] word_base;
  logic             word_ok;
  logic [IDX_W-1:0] pc_idx;
  logic             pc_ok;
  logic [IDX_W-1:0] pl_idx;
  logic             pl_ok;
  logic             wr_en;
  logic             pl_we;
  word_t            rd_word;
  byte_t            fe_byte;

  assign wr_en = wd_wr & word_ok;
  assign pl_we = pl_en & pl_ok;

  wb_addr_map #(
    .MEM_BYTES(MEM_BYTES), .WA_W(WA_W), .PC_W(PC_W), .IDX_W(IDX_W)
  ) u_map (
    .word_addr(wd_addr), .pc(if_pc), .pl_addr(pl_addr),
    .word_base(word_base), .word_ok(word_ok),
    .pc_idx(pc_idx), .pc_ok(pc_ok),
    .pl_idx(pl_idx), .pl_ok(pl_ok)
  );

  wb_byte_array #(
    .MEM_BYTES(MEM_BYTES), .IDX_W(IDX_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .word_base(word_base), .wr_en(wr_en), .wr_data(wd_wdata),
    .pl_en(pl_we), .pl_idx(pl_idx), .pl_data(pl_data),
    .fe_idx(pc_idx), .rd_word(rd_word), .fe_byte(fe_byte)
  );

  wb_resp_stage u_resp (
    .clk(clk), .rst_n(rst_n),
    .wd_rd(wd_rd), .wd_wr(wd_wr), .word_ok(word_ok), .rd_word(rd_word),
    .if_req(if_req), .pc_ok(pc_ok), .fe_byte(fe_byte),
    .wd_rdata(wd_rdata), .wd_valid(wd_valid), .wd_err(wd_err),
    .if_byte(if_byte), .if_valid(if_valid), .if_err(if_err)
  );
endmodule

// File: rtl/wb_shared_mem_chk.sv
module wb_shared_mem_chk #(
  parameter int MEM_BYTES = 1024,
  parameter int WA_W      = 10,
  parameter int PC_W      = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic [WA_W-1:0] wd_addr,
  input logic            wd_rd,
  input logic            wd_wr,
  input logic [31:0]     wd_rdata,
  input logic            wd_valid,
  input logic            wd_err,
  input logic [PC_W-1:0] if_pc,
  input logic            if_req,
  input logic [7:0]      if_byte,
  input logic            if_valid,
  input logic            if_err
);
  localparam logic [WA_W:0] WORDS  = (WA_W+1)'(MEM_BYTES / 4);
  localparam logic [PC_W:0] LAST_P = (PC_W+1)'(MEM_BYTES - 1);

  p_rd_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rd |=> wd_valid);
  p_no_rd_no_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_rd |=> !wd_valid);
  p_fetch_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    if_req |=> if_valid);
  p_no_req_no_fvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !if_req |=> !if_valid);
  p_err_data_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && wd_err) |-> (wd_rdata == '0));
  p_idle_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_rd || wd_wr) |=> !wd_err);
  p_in_range_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((wd_rd || wd_wr) && ({1'b0, wd_addr} < WORDS)) |=> !wd_err);
  p_fetch_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    if_err |-> (if_byte == '0));
  p_fetch_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && ({1'b0, if_pc} <= LAST_P)) |=> !if_err);
endmodule

bind wb_shared_mem wb_shared_mem_chk #(
  .MEM_BYTES(MEM_BYTES), .WA_W(WA_W), .PC_W(PC_W)
) u_chk (.*);

// File: tb/test_wb_shared_mem.sv
module test_wb_shared_mem;
  localparam int MEM  = 1024;
  localparam int WA_W = 10;
  localparam int PC_W = 11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [WA_W-1:0] wd_addr = '0;
  logic            wd_rd = 1'b0;
  logic            wd_wr = 1'b0;
  logic [31:0]     wd_wdata = '0;
  logic [31:0]     wd_rdata;
  logic            wd_valid;
  logic            wd_err;
  logic [PC_W-1:0] if_pc = '0;
  logic            if_req = 1'b0;
  logic [7:0]      if_byte;
  logic            if_valid;
  logic            if_err;
  logic            pl_en = 1'b0;
  logic [PC_W-1:0] pl_addr = '0;
  logic [7:0]      pl_data = '0;

  wb_shared_mem #(.MEM_BYTES(MEM), .WA_W(WA_W), .PC_W(PC_W)) i_wb_shared_mem (.*);

  always #4 clk = ~clk;

  typedef struct { int due; bit valid; bit err; logic [31:0] data; string tag; } exp_t;
  exp_t wq[$];
  exp_t fq[$];
  bit [7:0] model [MEM];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_on = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic clear_model();
    for (int i = 0; i < MEM; i++) model[i] = 8'h00;
  endtask

  // Driver: sets every input for one cycle, pushes expectations, updates the model.
  task automatic op(input bit rd, input bit wr, input int wa, input logic [31:0] wd,
                    input bit fr, input int pc, input bit pe, input int pa,
                    input logic [7:0] pd, input string tag);
    exp_t e;
    bit wok, fok;
    @(posedge clk); #2;
    wd_rd = rd; wd_wr = wr; wd_addr = WA_W'(wa); wd_wdata = wd;
    if_req = fr; if_pc = PC_W'(pc);
    pl_en = pe; pl_addr = PC_W'(pa); pl_data = pd;
    wok = (wa * 4 + 3) <= MEM - 1;
    fok = pc <= MEM - 1;
    if (rd || wr) begin
      e.due = cyc + 1; e.valid = rd; e.err = !wok; e.tag = tag;
      e.data = wok ? {model[wa*4+3], model[wa*4+2], model[wa*4+1], model[wa*4]} : 32'h0;
      wq.push_back(e);
    end
    if (fr) begin
      e.due = cyc + 1; e.valid = 1'b1; e.err = !fok; e.tag = tag;
      e.data = fok ? {24'h0, model[pc]} : 32'h0;
      fq.push_back(e);
    end
    if (pe && pa <= MEM - 1) model[pa] = pd;
    if (wr && wok) for (int k = 0; k < 4; k++) model[wa*4+k] = wd[k*8 +: 8];
  endtask

  task automatic idle();
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask
  task automatic wrd(input int wa, input string tag);
    op(1, 0, wa, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wwr(input int wa, input logic [31:0] d, input string tag);
    op(0, 1, wa, d, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic fetch(input int pc, input string tag);
    op(0, 0, 0, 0, 1, pc, 0, 0, 0, tag);
  endtask
  task automatic pload(input int a, input logic [7:0] d, input string tag);
    op(0, 0, 0, 0, 0, 0, 1, a, d, tag);
  endtask

  // Monitor: compares outputs with the queued expectations.
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (wq.size() > 0 && wq[0].due == cyc) begin
        exp_t e;
        e = wq.pop_front();
        checks++;
        if (wd_valid !== e.valid || wd_err !== e.err || (e.valid && wd_rdata !== e.data)) begin
          errors++;
          $display("FAIL %s word: valid=%0b err=%0b data=%h expected valid=%0b err=%0b data=%h",
                   e.tag, wd_valid, wd_err, wd_rdata, e.valid, e.err, e.data);
        end
      end else if (wd_valid !== 1'b0 || wd_err !== 1'b0) begin
        checks++; errors++;
        $display("FAIL R4/R6 spurious word response: valid=%0b err=%0b expected 0 0",
                 wd_valid, wd_err);
      end
      if (fq.size() > 0 && fq[0].due == cyc) begin
        exp_t e;
        e = fq.pop_front();
        checks++;
        if (if_valid !== 1'b1 || if_err !== e.err || if_byte !== e.data[7:0]) begin
          errors++;
          $display("FAIL %s fetch: valid=%0b err=%0b byte=%h expected valid=1 err=%0b byte=%h",
                   e.tag, if_valid, if_err, if_byte, e.err, e.data[7:0]);
        end
      end else if (if_valid !== 1'b0 || if_err !== 1'b0) begin
        checks++; errors++;
        $display("FAIL R3/R7 spurious fetch response: valid=%0b err=%0b expected 0 0",
                 if_valid, if_err);
      end
    end
  end

  task automatic check_reset_outputs();
    @(negedge clk);
    checks++;
    if (wd_valid !== 0 || wd_err !== 0 || wd_rdata !== 0 ||
        if_valid !== 0 || if_err !== 0 || if_byte !== 0) begin
      errors++;
      $display("FAIL R10 reset outputs: %0b %0b %h %0b %0b %h expected all zero",
               wd_valid, wd_err, wd_rdata, if_valid, if_err, if_byte);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    clear_model();
    repeat (3) @(posedge clk);
    check_reset_outputs();                        // R10
    @(posedge clk); #2; rst_n = 1'b1;
    mon_on = 1;

    // R5: unwritten bytes read zero
    wrd(0, "R5"); wrd(5, "R5"); fetch(7, "R5");

    // R8 preload then R3 fetch, R2 word view of preloaded bytes
    for (int i = 0; i < 8; i++) pload(i, 8'(8'h30 + i * 7), "R8");
    for (int i = 0; i < 8; i++) fetch(i, "R3");
    wrd(1, "R2");

    // R1/R2: word write, fetch its bytes in order
    wwr(3, 32'hA1B2C3D4, "R1");
    for (int i = 12; i < 16; i++) fetch(i, "R2");
    wrd(3, "R2");

    // R9: write and fetch/read same bytes in same cycle return old contents
    wwr(10, 32'h11223344, "R9");
    op(1, 1, 10, 32'h99AABBCC, 1, 40, 0, 0, 0, "R9");
    wrd(10, "R9"); fetch(43, "R9");

    // R5: partially filled word
    pload(50, 8'h5E, "R5");
    wrd(12, "R5");

    // R6: out-of-range word accesses
    wrd(256, "R6"); wrd(255, "R6");
    wwr(0, 32'h0BADF00D, "R6");
    wwr(256, 32'hFFFFFFFF, "R6");
    wrd(0, "R6");

    // R7: fetch range
    fetch(1024, "R7"); fetch(1023, "R7"); fetch(2047, "R7");

    // R8: out-of-range preload ignored, word write wins over preload
    pload(1024, 8'h77, "R8");
    fetch(0, "R8");
    op(0, 1, 20, 32'h55667788, 0, 0, 1, 80, 8'h11, "R8");
    fetch(80, "R8"); fetch(81, "R8");

    // R4: back-to-back reads of computed patterns
    for (int i = 30; i < 38; i++) wwr(i, 32'(i * 32'h01030507), "R4");
    for (int i = 30; i < 38; i++) wrd(i, "R4");
    op(1, 0, 33, 0, 1, 33 * 4 + 2, 0, 0, 0, "R4");
    idle(); idle();

    // R10: reset mid-run clears all contents
    @(posedge clk); #2; mon_on = 0; rst_n = 1'b0;
    clear_model(); wq.delete(); fq.delete();
    check_reset_outputs();
    @(posedge clk); #2; rst_n = 1'b1;
    idle(); mon_on = 1;
    wrd(3, "R10"); fetch(12, "R10"); fetch(40, "R10");
    idle(); idle(); idle();
    finish_run();
  end
endmodule